// File: doc/BRIEF.md
# Two-Argument Arctangent Core

The core returns the angle, in radians, from the positive X axis to the point (X, Y) for signed fixed-point coordinates. The quadrant is chosen from the signs of X and Y taken separately, so the answer covers the whole circle from −π to +π, rather than only the half-range that the ratio Y/X would give. A request is offered with a valid/ready handshake. The angle comes back some cycles later with a one-cycle done strobe.

Inside, a point with negative X is first mirrored through the origin into the right half-plane. Both coordinates are then normalised by a common left shift, which keeps small inputs accurate. An iterative vectoring rotation engine drives Y towards zero, doing one micro-rotation per clock. A finishing stage adds or subtracts π to undo the mirror. It then rounds the angle to the output grid and reports two flags: whether rounding raised the magnitude, and whether the delivered value differs from the internal pre-rounding value. Both inputs must be nonzero. Zeros, infinities and invalid values are handled by the caller.

Top module: `atan2_cordic`

## Requirements
- R1: Operands are captured on the rising edge where valid_i and ready_o are both high; ready_o stays low from that edge until the edge that raises done_o.
- R2: done_o is high for exactly one cycle, following the 17th rising edge after the capture edge, and ready_o returns high on that same edge.
- R3: Changes on valid_i, x_i or y_i while ready_o is low have no effect on the delivered angle or its timing.
- R4: angle_o is 18-bit two's complement with 15 fractional bits (1 LSB = 2^-15 rad) and lies within 4 LSB of atan2(Y, X)·2^15 for any nonzero 16-bit X and Y, including −32768.
- R5: With X < 0 and Y > 0 the angle lies between +π/2 and +π (within the R4 tolerance at the π/2 edge).
- R6: With X > 0 and Y < 0 the angle lies between 0 and −π/2 (within the R4 tolerance at the −π/2 edge).
- R7: With X < 0 and Y < 0 the angle lies between −π/2 and −π (within the R4 tolerance at the −π/2 edge).
- R8: The sign bit of angle_o (bit 17) equals the sign of Y, and angle_o is never zero.
- R9: The magnitude of angle_o never exceeds 102943, the largest code below π.
- R10: rounded_up_o is 1 when the delivered magnitude was raised above the internal value: the first discarded bit was set, or the result was lifted to one LSB to keep the sign of Y. It is 0 when the result was clamped below π, and it is never 1 without inexact_o.
- R11: inexact_o is 1 when any discarded fraction bit is nonzero, or when a clamp or lift changed the result.
- R12: During and after reset, ready_o is 1, and done_o, angle_o, rounded_up_o and inexact_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair offered |
| ready_o | output | 1 | Core idle and able to capture operands |
| x_i | input | 16 | Abscissa X, two's complement |
| y_i | input | 16 | Ordinate Y, two's complement |
| done_o | output | 1 | One-cycle strobe marking a new result |
| angle_o | output | 18 | Angle in radians, two's complement, 15 fractional bits |
| rounded_up_o | output | 1 | Rounding raised the magnitude |
| inexact_o | output | 1 | Delivered angle differs from the internal value |

## Verification
Several properties are checked on every cycle by the assertions. Each result must carry the sign of Y, be nonzero and stay below π. The rounded-up flag must never appear without the inexact flag. The done strobe must last a single cycle. The mirror and sign state captured at the start must hold steady while the engine iterates, and the working abscissa must stay positive throughout the rotations. Only the bench scenarios can show the rest: numerical accuracy against a real-valued atan2, the quadrant windows for each sign combination, the exact 17-edge latency, and the fact that traffic offered while busy leaves the result untouched.

// File: rtl/atan2_pkg.sv
`timescale 1ns / 1ps
package atan2_pkg;

  localparam real PI_R = 3.14159265358979323846;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_LAST = 2'd2
  } eng_state_e;

  // round(atan(2^-idx) * 2^frac)
  function automatic int atan_step_code(input int idx, input int frac);
    real a;
    a = $atan($pow(2.0, -idx)) * $pow(2.0, frac);
    return $rtoi(a + 0.5);
  endfunction

  function automatic int pi_round_code(input int frac);
    return $rtoi(PI_R * $pow(2.0, frac) + 0.5);
  endfunction

  function automatic int pi_floor_code(input int frac);
    return $rtoi(PI_R * $pow(2.0, frac));
  endfunction

endpackage

// File: rtl/atan2_prefold.sv
`timescale 1ns / 1ps
module atan2_prefold #(
  parameter int IN_W     = 16,
  parameter int XY_W     = 24,
  parameter int XY_GUARD = 4
) (
  input  logic signed [IN_W-1:0] x_i,
  input  logic signed [IN_W-1:0] y_i,
  output logic signed [XY_W-1:0] x_o,
  output logic signed [XY_W-1:0] y_o,
  output logic                   fold_o,
  output logic                   y_neg_o
);
  localparam int EXT_W = IN_W + 1;
  localparam int LZ_W  = $clog2(EXT_W + 1);

  logic signed [EXT_W-1:0] x_e, y_e, x_f, y_f;
  logic        [EXT_W-1:0] y_abs, mag_or;
  logic        [LZ_W-1:0]  lz;
  logic        [LZ_W:0]    sh;

  assign fold_o  = x_i[IN_W-1];
  assign y_neg_o = y_i[IN_W-1];

  always_comb begin
    x_e = {x_i[IN_W-1], x_i};
    y_e = {y_i[IN_W-1], y_i};
    // mirror through origin into right half-plane
    x_f = fold_o ? -x_e : x_e;
    y_f = fold_o ? -y_e : y_e;
    y_abs  = y_f[EXT_W-1] ? $unsigned(-y_f) : $unsigned(y_f);
    mag_or = $unsigned(x_f) | y_abs;
    lz = '0;
    for (int b = 0; b < EXT_W; b++) begin
      if (mag_or[b]) lz = LZ_W'(EXT_W - 1 - b);
    end
    sh  = {1'b0, lz} + (LZ_W + 1)'(XY_GUARD);
    x_o = XY_W'(x_f) <<< sh;
    y_o = XY_W'(y_f) <<< sh;
  end

endmodule

// File: rtl/atan2_cordic_iter.sv
`timescale 1ns / 1ps
module atan2_cordic_iter
  import atan2_pkg::*;
#(
  parameter int XY_W     = 24,
  parameter int ANG_W    = 23,
  parameter int ANG_FRAC = 20,
  parameter int ITER     = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic signed [XY_W-1:0]  x_i,
  input  logic signed [XY_W-1:0]  y_i,
  input  logic                    fold_i,
  input  logic                    y_neg_i,
  output logic                    busy_o,
  output logic                    last_o,
  output logic signed [ANG_W-1:0] z_o,
  output logic                    fold_o,
  output logic                    y_neg_o
);
  localparam int IT_W = (ITER > 1) ? $clog2(ITER) : 1;

  eng_state_e              state_q;
  logic signed [XY_W-1:0]  x_q, y_q, x_nx, y_nx, xs, ys;
  logic signed [ANG_W-1:0] z_q, z_nx;
  logic        [IT_W-1:0]  it_q;
  logic                    fold_q, yneg_q;
  logic signed [ANG_W-1:0] lut [ITER];

  for (genvar g = 0; g < ITER; g++) begin : g_lut
    assign lut[g] = ANG_W'(atan_step_code(g, ANG_FRAC));
  end

  always_comb begin
    xs = x_q >>> it_q;
    ys = y_q >>> it_q;
    if (y_q[XY_W-1]) begin
      x_nx = x_q - ys;
      y_nx = y_q + xs;
      z_nx = z_q - lut[it_q];
    end else begin
      x_nx = x_q + ys;
      y_nx = y_q - xs;
      z_nx = z_q + lut[it_q];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      z_q     <= '0;
      it_q    <= '0;
      fold_q  <= 1'b0;
      yneg_q  <= 1'b0;
    end else begin
      case (state_q)
        ENG_IDLE: if (start_i) begin
          x_q     <= x_i;
          y_q     <= y_i;
          z_q     <= '0;
          it_q    <= '0;
          fold_q  <= fold_i;
          yneg_q  <= y_neg_i;
          state_q <= ENG_RUN;
        end
        ENG_RUN: begin
          x_q  <= x_nx;
          y_q  <= y_nx;
          z_q  <= z_nx;
          it_q <= it_q + IT_W'(1);
          if (it_q == IT_W'(ITER - 1)) state_q <= ENG_LAST;
        end
        ENG_LAST: state_q <= ENG_IDLE;
        default:  state_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ENG_IDLE);
  assign last_o  = (state_q == ENG_LAST);
  assign z_o     = z_q;
  assign fold_o  = fold_q;
  assign y_neg_o = yneg_q;

  p_operands_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ENG_RUN) |=> ($stable(fold_q) && $stable(yneg_q)));

  p_x_positive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ENG_RUN) |-> (x_q > 0));

  p_last_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ENG_LAST) |=> (state_q == ENG_IDLE));

endmodule

// File: rtl/atan2_finish.sv
`timescale 1ns / 1ps
module atan2_finish
  import atan2_pkg::*;
#(
  parameter int OUT_W    = 18,
  parameter int OUT_FRAC = 15,
  parameter int GUARD    = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          last_i,
  input  logic signed [OUT_W+GUARD-1:0] z_i,
  input  logic                          fold_i,
  input  logic                          y_neg_i,
  output logic signed [OUT_W-1:0]       angle_o,
  output logic                          done_o,
  output logic                          rounded_up_o,
  output logic                          inexact_o
);
  localparam int ANG_W = OUT_W + GUARD;
  localparam logic signed [ANG_W-1:0] PI_INT =
    ANG_W'(pi_round_code(OUT_FRAC)) <<< GUARD;
  localparam logic [OUT_W-1:0] PI_MAX = OUT_W'(pi_floor_code(OUT_FRAC));
  localparam logic signed [OUT_W-1:0] PI_MAX_S = $signed(PI_MAX);

  logic signed [ANG_W-1:0] offs, sum;
  logic        [ANG_W-1:0] mag;
  logic        [OUT_W-1:0] rnd, mag_fin;
  logic                    rbit, lost, adj, up;
  logic signed [OUT_W-1:0] angle_n;

  always_comb begin
    offs = fold_i ? (y_neg_i ? -PI_INT : PI_INT) : '0;
    sum  = z_i + offs;
    mag  = sum[ANG_W-1] ? $unsigned(-sum) : $unsigned(sum);
    rbit = mag[GUARD-1];
    lost = |mag[GUARD-1:0];
    rnd  = mag[ANG_W-1:GUARD] + OUT_W'(rbit);
    if ((sum[ANG_W-1] != y_neg_i) || (rnd == '0)) begin
      // keep sign of Y: lift to one LSB
      mag_fin = OUT_W'(1);
      up      = 1'b1;
      adj     = 1'b1;
    end else if (rnd > PI_MAX) begin
      mag_fin = PI_MAX;
      up      = 1'b0;
      adj     = 1'b1;
    end else begin
      mag_fin = rnd;
      up      = rbit;
      adj     = 1'b0;
    end
    angle_n = y_neg_i ? -$signed(mag_fin) : $signed(mag_fin);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      angle_o      <= '0;
      rounded_up_o <= 1'b0;
      inexact_o    <= 1'b0;
    end else begin
      done_o <= last_i;
      if (last_i) begin
        angle_o      <= angle_n;
        rounded_up_o <= up;
        inexact_o    <= lost | adj;
      end
    end
  end

  p_sign_follows_y_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((angle_o[OUT_W-1] == y_neg_i) && (angle_o != '0)));

  p_below_pi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((angle_o <= PI_MAX_S) && (angle_o >= -PI_MAX_S)));

  p_up_needs_inexact_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && rounded_up_o) |-> inexact_o);

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: rtl/atan2_cordic.sv
`timescale 1ns / 1ps
module atan2_cordic #(
  parameter int IN_W     = 16,
  parameter int OUT_W    = 18,
  parameter int OUT_FRAC = 15,
  parameter int ITER     = 16,
  parameter int GUARD    = 5,
  parameter int XY_GUARD = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  output logic                    ready_o,
  input  logic signed [IN_W-1:0]  x_i,
  input  logic signed [IN_W-1:0]  y_i,
  output logic                    done_o,
  output logic signed [OUT_W-1:0] angle_o,
  output logic                    rounded_up_o,
  output logic                    inexact_o
);
  localparam int XY_W     = IN_W + XY_GUARD + 4;
  localparam int ANG_W    = OUT_W + GUARD;
  localparam int ANG_FRAC = OUT_FRAC + GUARD;

  logic signed [XY_W-1:0]  fx, fy;
  logic                    ffold, fyneg;
  logic                    busy, last, start;
  logic signed [ANG_W-1:0] z;
  logic                    e_fold, e_yneg;

  assign ready_o = ~busy;
  assign start   = valid_i & ready_o;

  atan2_prefold #(
    .IN_W(IN_W), .XY_W(XY_W), .XY_GUARD(XY_GUARD)
  ) u_prefold (
    .x_i(x_i), .y_i(y_i), .x_o(fx), .y_o(fy), .fold_o(ffold), .y_neg_o(fyneg)
  );

  atan2_cordic_iter #(
    .XY_W(XY_W), .ANG_W(ANG_W), .ANG_FRAC(ANG_FRAC), .ITER(ITER)
  ) u_iter (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .x_i(fx), .y_i(fy), .fold_i(ffold), .y_neg_i(fyneg),
    .busy_o(busy), .last_o(last), .z_o(z), .fold_o(e_fold), .y_neg_o(e_yneg)
  );

  atan2_finish #(
    .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC), .GUARD(GUARD)
  ) u_finish (
    .clk_i(clk_i), .rst_ni(rst_ni), .last_i(last), .z_i(z),
    .fold_i(e_fold), .y_neg_i(e_yneg),
    .angle_o(angle_o), .done_o(done_o),
    .rounded_up_o(rounded_up_o), .inexact_o(inexact_o)
  );

  p_ready_on_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);

  p_busy_after_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !ready_o);

endmodule

// File: tb/atan2_cordic_tb.sv
`timescale 1ns / 1ps
module atan2_cordic_tb;
  localparam int    NV     = 20;
  localparam int    TOL    = 4;
  localparam int    HALF   = 51472;
  localparam int    PIMAX  = 102943;
  localparam real   SCALE  = 32768.0;

  localparam logic signed [15:0] VX [NV] = '{
    30000, 200, 1, 32767, 1000,
    -30000, -5, -32768, -1, -7000,
    -30000, -32768, -100, -1, -32768,
    30000, 3, 32767, 1, 16000};
  localparam logic signed [15:0] VY [NV] = '{
    5000, 30000, 1, 32767, 1,
    5000, 32000, 1, 1, 7000,
    -5000, -32768, -31000, -1, -1,
    -5000, -32768, -1, -1, -9};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [15:0] x_i = '0, y_i = '0;
  logic ready_o, done_o, rounded_up_o, inexact_o;
  logic signed [17:0] angle_o;

  int checks = 0, fails = 0;
  int seen_up = 0, seen_noup = 0, seen_inex = 0;

  always #5 clk = ~clk;

  atan2_cordic u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
    .x_i(x_i), .y_i(y_i), .done_o(done_o), .angle_o(angle_o),
    .rounded_up_o(rounded_up_o), .inexact_o(inexact_o));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // offer one operand pair; returns edges from capture to done
  task automatic run(input logic signed [15:0] x, input logic signed [15:0] y,
                     input bit disturb, output int lat);
    @(negedge clk);
    check(ready_o == 1'b1, "R1", "ready before offer", ready_o, 1);
    valid_i = 1'b1; x_i = x; y_i = y;
    @(posedge clk);
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (disturb) begin
        valid_i = 1'b1; x_i = -x_i ^ 16'h0155; y_i = ~y_i;
      end else begin
        valid_i = 1'b0;
      end
      if (lat == 8) check(ready_o == 1'b0, "R1", "ready while busy", ready_o, 0);
    end while (!done_o && lat < 40);
    valid_i = 1'b0;
  endtask

  function automatic real ref_code(input int x, input int y);
    return $atan2(real'(y), real'(x)) * SCALE;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    real r, d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 during reset
    check(ready_o == 1 && done_o == 0, "R12", "handshake in reset", {ready_o, done_o}, 2);
    check(angle_o == 0 && rounded_up_o == 0 && inexact_o == 0, "R12", "outputs in reset",
          angle_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(ready_o == 1 && done_o == 0 && angle_o == 0, "R12", "after reset", angle_o, 0);

    for (int i = 0; i < NV; i++) begin
      run(VX[i], VY[i], 1'b0, lat);
      r = ref_code(VX[i], VY[i]);
      d = real'(angle_o) - r;
      check(lat == 17, "R2", "latency", lat, 17);
      check(d <= TOL && d >= -TOL, "R4", "accuracy vs atan2", angle_o, $rtoi(r));
      check(angle_o[17] == VY[i][15] && angle_o != 0, "R8", "sign of Y",
            angle_o, VY[i][15] ? -1 : 1);
      check(angle_o <= PIMAX && angle_o >= -PIMAX, "R9", "below pi", angle_o, PIMAX);
      check(!rounded_up_o || inexact_o, "R10", "rounded_up implies inexact",
            inexact_o, 1);
      if (VX[i] < 0 && VY[i] > 0)
        check(angle_o >= HALF - TOL, "R5", "second quadrant", angle_o, HALF);
      else if (VX[i] > 0 && VY[i] < 0)
        check(angle_o < 0 && angle_o >= -HALF - TOL, "R6", "fourth quadrant",
              angle_o, -HALF);
      else if (VX[i] < 0 && VY[i] < 0)
        check(angle_o <= -HALF + TOL, "R7", "third quadrant", angle_o, -HALF);
      else
        check(angle_o > 0 && angle_o <= HALF + TOL, "R4", "first quadrant", angle_o, HALF);
      if (rounded_up_o) seen_up++; else seen_noup++;
      if (inexact_o) seen_inex++;
    end

    check(seen_up > 0 && seen_noup > 0, "R10", "rounded_up takes both values",
          seen_up, 1);
    check(seen_inex > 0, "R11", "inexact raised", seen_inex, 1);

    // R3: traffic while busy is ignored
    run(-30000, 5000, 1'b1, lat);
    r = ref_code(-30000, 5000);
    d = real'(angle_o) - r;
    check(lat == 17, "R3", "latency with busy traffic", lat, 17);
    check(d <= TOL && d >= -TOL, "R3", "result with busy traffic", angle_o, $rtoi(r));

    // R2: done is a single-cycle pulse, ready back with it
    check(ready_o == 1'b1, "R2", "ready with done", ready_o, 1);
    @(negedge clk);
    check(done_o == 1'b0, "R2", "done width", done_o, 0);

    // R4 extreme operands back to back
    run(-32768, 32767, 1'b0, lat);
    r = ref_code(-32768, 32767);
    d = real'(angle_o) - r;
    check(d <= TOL && d >= -TOL, "R4", "extreme operands", angle_o, $rtoi(r));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule